// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Frame Re-alignment

This block receives asynchronous serial characters on a single line input. An external rate generator supplies a one-cycle `sample_tick` at 16 times the bit rate in normal mode, or at 8 times the bit rate when `dbl_speed` is high. The receiver waits for a low sample on an idle line and starts its sample count there, so every frame sets its own sampling phase. It recovers each bit by a 2-of-3 majority vote over three samples taken at the middle of the bit.

A frame has one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each finished character goes into a two-entry receive buffer together with its own parity-error and frame-error flags. The host reads the head character with `rd_stb`. `rx_full` stays high as long as unread characters remain, so the host drains the buffer by reading until `rx_full` drops.

Clearing `rx_en` aborts any frame that is being received, empties the buffer and lowers `pin_override`. That output tells the pad logic that the line is no longer claimed by the receiver.

Top module: `uart_rx_recover`

## Requirements
- R1: The bit period is 16 sample ticks when `dbl_speed`=0 and 8 sample ticks when `dbl_speed`=1. The value is latched at the start of each frame.
- R2: While the line is idle the sample count is zero. The first low sample seen while idle is sample 1 of the start bit, so the bit timing is re-aligned to every frame.
- R3: Each bit is the 2-of-3 majority of its samples 8, 9 and 10 (16x mode) or 4, 5 and 6 (8x mode). One wrong sample among them, or any wrong sample outside them, does not change the bit. Two wrong voted samples do change it.
- R4: If the voted start bit is high, the frame is dropped as a glitch. No character is stored, and the receiver goes back to looking for a low sample.
- R5: `par_mode` encoding: 2'b00 or 2'b01 means no parity bit, 2'b10 means even parity, 2'b11 means odd parity. Data bits arrive least significant bit first, and `rd_data` bit 0 is the first data bit received.
- R6: `par_err` belongs to the head character. It is 1 only if parity was enabled when that character arrived and the received parity bit did not match. It stays the same until that character is read, even if `par_mode` changes.
- R7: `frm_err` of a character is 1 when its voted stop bit is low. The data is still stored.
- R8: The buffer holds two characters. A character that arrives while the buffer is full is discarded. `rx_full` is high whenever the buffer holds an unread character. `rd_stb` removes the head character, and `rd_stb` on an empty buffer has no effect.
- R9: When `rx_en` is low, a frame in progress is discarded and the buffer is emptied within one clock. Nothing is received while `rx_en` stays low.
- R10: `pin_override` equals `rx_en` delayed by one clock and is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line input, idle high |
| sample_tick | input | 1 | One-cycle oversampling strobe |
| dbl_speed | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| par_mode | input | 2 | Parity selection (see R5) |
| rd_stb | input | 1 | Read strobe, removes the head character |
| rd_data | output | 8 | Head character data |
| rx_full | output | 1 | Unread character present |
| par_err | output | 1 | Parity error of the head character |
| frm_err | output | 1 | Frame error of the head character |
| pin_override | output | 1 | Receiver claims the line input |

## Verification
A sample counter at the wrong phase moves the voting window off the middle of the bit. This shows up within one frame: a single corrupted sample at the edge of the window then changes `rd_data`. A wrong buffer pointer or count shows up at the next read as a repeated, lost or stale character, or as `rx_full` not agreeing with the number of characters sent. A flag taken from the wrong entry, or an abort that leaves state behind, shows up on the first character read after the event.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_phase_e;
endpackage

// File: rtl/rxr_bit_engine.sv
module rxr_bit_engine #(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic          dbl,
  input  logic [1:0]    par_mode,
  output logic          push,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);
  import rxr_pkg::*;

  localparam int CW = $clog2(OSR_NORM + 1);
  localparam int BW = $clog2(DW + 1);

  rx_phase_e     phase;
  logic [CW-1:0] cnt, cnt_nxt, nsamp, vpos;
  logic          s0, s1, maj, at_vote;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bidx;
  logic          dbl_q, pen_q, podd_q, pbit;

  always_comb begin
    nsamp   = dbl_q ? CW'(OSR_DBL) : CW'(OSR_NORM);
    vpos    = nsamp >> 1;
    cnt_nxt = (cnt == nsamp) ? CW'(1) : cnt + CW'(1);
    maj     = (s0 & s1) | (s0 & rxd) | (s1 & rxd);
    at_vote = tick && (phase != RX_IDLE) && (cnt_nxt == vpos + CW'(2));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase  <= RX_IDLE;
      cnt    <= '0;
      push   <= 1'b0;
      bidx   <= '0;
      dbl_q  <= 1'b0;
      pen_q  <= 1'b0;
      podd_q <= 1'b0;
      pbit   <= 1'b0;
      s0     <= 1'b1;
      s1     <= 1'b1;
      shreg  <= '0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        if (phase == RX_IDLE) begin
          if (!rxd) begin
            phase  <= RX_START;
            cnt    <= CW'(1);
            dbl_q  <= dbl;
            pen_q  <= par_mode[1];
            podd_q <= par_mode[0];
          end
        end else begin
          cnt <= cnt_nxt;
          if (cnt_nxt == vpos)           s0 <= rxd;
          if (cnt_nxt == vpos + CW'(1))  s1 <= rxd;
          if (at_vote) begin
            case (phase)
              RX_START: begin
                if (maj) begin
                  phase <= RX_IDLE;
                  cnt   <= '0;
                end else begin
                  phase <= RX_DATA;
                  bidx  <= '0;
                end
              end
              RX_DATA: begin
                shreg <= {maj, shreg[DW-1:1]};
                bidx  <= bidx + BW'(1);
                if (bidx == BW'(DW - 1)) phase <= pen_q ? RX_PAR : RX_STOP;
              end
              RX_PAR: begin
                pbit  <= maj;
                phase <= RX_STOP;
              end
              RX_STOP: begin
                push   <= 1'b1;
                data_o <= shreg;
                perr_o <= pen_q && ((^shreg ^ pbit) != podd_q);
                ferr_o <= !maj;
                phase  <= RX_IDLE;
                cnt    <= '0;
              end
              default: phase <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R2: the counter rests at zero while the line is idle
  a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
    (phase == RX_IDLE) |-> (cnt == '0));

  // R1: in 8x mode the count never passes the shorter bit period
  a_r1_dbl_count_bound: assert property (@(posedge clk) disable iff (rst)
    (phase != RX_IDLE && dbl_q) |-> (cnt <= CW'(OSR_DBL)));

  // R4: a high start vote returns the receiver to idle
  a_r4_glitch_to_idle: assert property (@(posedge clk) disable iff (rst)
    (en && at_vote && phase == RX_START && maj) |=> (phase == RX_IDLE));

  // R9: disabling aborts the frame and stores nothing
  a_r9_abort_frame: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (phase == RX_IDLE && !push));
endmodule

// File: rtl/rxr_char_buf.sv
module rxr_char_buf #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   rptr, wptr;
  logic [CNTW-1:0] count;
  logic            wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wr_ok     = push && !flush && (count != CNTW'(DEPTH));
  assign rd_ok     = pop && !flush && (count != '0);
  assign head      = mem[rptr];
  assign not_empty = (count != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= ptr_inc(wptr);
      if (rd_ok) rptr <= ptr_inc(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  // R8: never more than DEPTH characters held
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));

  // R8: a character arriving on a full buffer is dropped
  a_r8_full_drops: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && count == CNTW'(DEPTH)) |=> (count == CNTW'(DEPTH)));

  // R8: reading an empty buffer changes nothing
  a_r8_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !flush && count == '0) |=> (count == '0));

  // R9: a flush leaves the buffer empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover #(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  parameter int DW       = 8,
  parameter int DEPTH    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic          sample_tick,
  input  logic          dbl_speed,
  input  logic [1:0]    par_mode,
  input  logic          rd_stb,
  output logic [DW-1:0] rd_data,
  output logic          rx_full,
  output logic          par_err,
  output logic          frm_err,
  output logic          pin_override
);
  localparam int EW = DW + 2;

  logic          eng_push, eng_perr, eng_ferr;
  logic [DW-1:0] eng_data;
  logic [EW-1:0] head;

  rxr_bit_engine #(.OSR_NORM(OSR_NORM), .OSR_DBL(OSR_DBL), .DW(DW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .tick     (sample_tick),
    .rxd      (rxd),
    .dbl      (dbl_speed),
    .par_mode (par_mode),
    .push     (eng_push),
    .data_o   (eng_data),
    .perr_o   (eng_perr),
    .ferr_o   (eng_ferr)
  );

  rxr_char_buf #(.DEPTH(DEPTH), .W(EW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .flush     (!rx_en),
    .push      (eng_push),
    .wdata     ({eng_perr, eng_ferr, eng_data}),
    .pop       (rd_stb),
    .head      (head),
    .not_empty (rx_full)
  );

  assign rd_data = head[DW-1:0];
  assign frm_err = head[DW];
  assign par_err = head[DW+1];

  always_ff @(posedge clk) begin
    if (rst) pin_override <= 1'b0;
    else     pin_override <= rx_en;
  end

  // R10: the line claim drops once the receiver is disabled
  a_r10_release_line: assert property (@(posedge clk) disable iff (rst)
    (!rx_en) |=> (!pin_override));

  // R6: head character and its flags hold until read
  a_r6_head_stable: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_stb && rx_en) |=>
      ($stable(rd_data) && $stable(par_err) && $stable(frm_err)));
endmodule

// File: tb/sim_uart_rx_recover.sv
module sim_uart_rx_recover;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       rxd = 1'b1;
  logic       sample_tick = 1'b0;
  logic       dbl_speed = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       rx_full, par_err, frm_err, pin_override;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_recover u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .sample_tick(sample_tick),
    .dbl_speed(dbl_speed), .par_mode(par_mode), .rd_stb(rd_stb),
    .rd_data(rd_data), .rx_full(rx_full), .par_err(par_err),
    .frm_err(frm_err), .pin_override(pin_override)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    @(negedge clk);
    rxd = v;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // cb: frame bit to corrupt (0 = start); cs1/cs2: samples inverted (1-based)
  task automatic send_frame(input logic [7:0] d, input logic [1:0] pm,
                            input bit pflip, input bit stopv,
                            input int cb, input int cs1, input int cs2,
                            input int lim);
    int nsp;
    int nb;
    logic b;
    nsp = dbl_speed ? 8 : 16;
    nb  = pm[1] ? 11 : 10;
    par_mode = pm;
    for (int i = 0; i < nb && i < lim; i++) begin
      if (i == 0)            b = 1'b0;
      else if (i <= 8)       b = d[i-1];
      else if (i == nb - 1)  b = stopv;
      else                   b = (^d) ^ pm[0] ^ pflip;
      for (int s = 1; s <= nsp; s++)
        slot((i == cb && (s == cs1 || s == cs2)) ? ~b : b);
    end
    if (lim >= nb) for (int k = 0; k < 6; k++) slot(1'b1);
  endtask

  task automatic read_check(input logic [7:0] d, input bit pe, input bit fe, input string tag);
    @(negedge clk);
    chk(rx_full == 1'b1, {tag, " rx_full"}, rx_full, 1);
    chk(rd_data == d, {tag, " data"}, rd_data, d);
    chk(par_err == pe, {tag, " par_err"}, par_err, pe);
    chk(frm_err == fe, {tag, " frm_err"}, frm_err, fe);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    chk(rx_full == 1'b0, {tag, " empty"}, rx_full, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (run hung)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rx_full == 1'b0, "R8 reset rx_full", rx_full, 0);
    chk(pin_override == 1'b0, "R10 reset override", pin_override, 0);
    rst = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pin_override == 1'b1, "R10 override after enable", pin_override, 1);
    for (int k = 0; k < 3; k++) slot(1'b1);

    // R1 R5 16x mode, no parity and both parity senses
    send_frame(8'hA5, 2'b00, 0, 1, -1, 0, 0, 99);
    read_check(8'hA5, 0, 0, "R1 R5 no parity");
    send_frame(8'h3C, 2'b01, 0, 1, -1, 0, 0, 99);
    read_check(8'h3C, 0, 0, "R5 mode 01 no parity");
    send_frame(8'h3D, 2'b10, 0, 1, -1, 0, 0, 99);
    read_check(8'h3D, 0, 0, "R5 even good");
    send_frame(8'h81, 2'b11, 0, 1, -1, 0, 0, 99);
    read_check(8'h81, 0, 0, "R5 odd good");
    send_frame(8'h81, 2'b10, 1, 1, -1, 0, 0, 99);
    read_check(8'h81, 1, 0, "R6 even bad");
    send_frame(8'h07, 2'b11, 1, 1, -1, 0, 0, 99);
    read_check(8'h07, 1, 0, "R6 odd bad");

    // R6 flag kept per character when parity mode changes afterwards
    send_frame(8'h55, 2'b10, 1, 1, -1, 0, 0, 99);
    par_mode = 2'b00;
    slot(1'b1);
    read_check(8'h55, 1, 0, "R6 flag survives mode change");

    // R3 single wrong samples in and outside the window
    begin
      int sl[7] = '{8, 9, 10, 1, 7, 11, 16};
      foreach (sl[j]) begin
        send_frame(8'h5A, 2'b00, 0, 1, 4, sl[j], -1, 99);
        read_check(8'h5A, 0, 0, "R3 single wrong sample");
      end
    end
    send_frame(8'h5A, 2'b00, 0, 1, 0, 9, -1, 99);
    read_check(8'h5A, 0, 0, "R3 R2 start sample wrong");
    send_frame(8'h5A, 2'b00, 0, 1, 4, 8, 9, 99);
    read_check(8'h52, 0, 0, "R3 two wrong samples flip bit");
    send_frame(8'h5A, 2'b00, 0, 1, 4, 7, 11, 99);
    read_check(8'h5A, 0, 0, "R3 two wrong outside window");

    // R7 frame error
    send_frame(8'hC3, 2'b00, 0, 0, -1, 0, 0, 99);
    read_check(8'hC3, 0, 1, "R7 low stop");
    expect_empty("R4 R7 no extra char after low stop");

    // R4 start glitch
    for (int k = 0; k < 3; k++) slot(1'b0);
    for (int k = 0; k < 20; k++) slot(1'b1);
    expect_empty("R4 glitch ignored");
    for (int k = 0; k < 7; k++) slot(1'b0);
    for (int k = 0; k < 20; k++) slot(1'b1);
    expect_empty("R4 seven-sample glitch ignored");
    send_frame(8'h96, 2'b00, 0, 1, -1, 0, 0, 99);
    read_check(8'h96, 0, 0, "R2 R4 realigned after glitch");

    // R8 buffer depth, overflow drop, drain, empty read
    send_frame(8'h11, 2'b10, 1, 1, -1, 0, 0, 99);
    send_frame(8'h22, 2'b00, 0, 0, -1, 0, 0, 99);
    send_frame(8'h33, 2'b00, 0, 1, -1, 0, 0, 99);
    read_check(8'h11, 1, 0, "R8 first of full buffer");
    read_check(8'h22, 0, 1, "R8 second of full buffer");
    expect_empty("R8 third dropped");
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    expect_empty("R8 empty read ignored");
    send_frame(8'h44, 2'b00, 0, 1, -1, 0, 0, 99);
    read_check(8'h44, 0, 0, "R8 after empty read");
    expect_empty("R8 drained");

    // R9 R10 disable flushes and aborts
    send_frame(8'hE1, 2'b00, 0, 1, -1, 0, 0, 99);
    send_frame(8'hE2, 2'b00, 0, 1, -1, 0, 0, 99);
    send_frame(8'hF0, 2'b00, 0, 1, -1, 0, 0, 4);
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    chk(rx_full == 1'b0, "R9 flush on disable", rx_full, 0);
    chk(pin_override == 1'b0, "R10 override released", pin_override, 0);
    for (int k = 0; k < 40; k++) slot(1'b0);
    for (int k = 0; k < 5; k++) slot(1'b1);
    chk(rx_full == 1'b0, "R9 nothing while disabled", rx_full, 0);
    rx_en = 1'b1;
    for (int k = 0; k < 3; k++) slot(1'b1);
    send_frame(8'h69, 2'b11, 0, 1, -1, 0, 0, 99);
    read_check(8'h69, 0, 0, "R9 clean after re-enable");
    expect_empty("R9 partial frame discarded");

    // R1 R3 R5 R6 8x mode sweep over all bytes
    dbl_speed = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [1:0] pm;
      bit fl;
      int cb;
      pm = (v % 3 == 0) ? 2'b00 : ((v % 3 == 1) ? 2'b10 : 2'b11);
      fl = (v % 5 == 0) && pm[1];
      cb = (v % 4 == 0) ? (v % 8) + 1 : -1;
      send_frame(8'(v), pm, fl, 1, cb, 4 + (v % 3), -1, 99);
      read_check(8'(v), fl, 0, "R1 R3 R6 8x sweep");
    end
    send_frame(8'h5A, 2'b00, 0, 1, 4, 4, 5, 99);
    read_check(8'h52, 0, 0, "R3 8x two wrong samples");
    send_frame(8'h5A, 2'b00, 0, 1, 4, 3, 7, 99);
    read_check(8'h5A, 0, 0, "R3 8x outside window");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule